// File: doc/BRIEF.md
# Tag-Tracking Reservation Station with Flag Renaming

This block holds instructions for one functional-unit class until their operands exist. The issue stage presents groups of up to `ISSUE_W` instructions. Each instruction carries a unique producer tag, up to two source registers, an optional destination register, and bits saying whether it reads or writes the condition flags. An accepted group is written into free entries in slot order. For each source the station records either "ready" or the tag of the instruction that will produce it. A per-register status table and one global flag-producer register supply those tags. The flags are renamed in the same way as a register.

Write-back tags arrive on up to `WB_W` lanes per cycle. A matching tag wakes every entry waiting on it, clears any status-table or flag-register slot still pointing at it, and frees the entry that produced it. Among the ready entries that have not yet been sent, the station offers the oldest one (by allocation age, not by entry position) to the unit. The free-entry count goes back to the issue stage on every cycle. Only tags and readiness are held; operand values and execution live elsewhere.

Back-pressure rules:
- **Issue side:** a group moves when `iss_valid` and `iss_ready` are both high. `iss_ready` depends only on the station's own state, never on `iss_valid`.
- **Dispatch side:** an instruction leaves when `dsp_valid` and `dsp_ready` are both high. While `dsp_ready` is low, `dsp_valid` stays high, but the offered tag may change to an older entry that has just become ready.

Top module: `rs_station`

## Requirements
- R1: After reset, `free_cnt` equals `NUM_ENTRIES`, `dsp_valid` is low and `iss_ready` is high.
- R2: `iss_ready` is high exactly when `free_cnt >= ISSUE_W`. A group presented while `iss_ready` is low is dropped and changes neither `free_cnt` nor what is offered for dispatch.
- R3: `free_cnt` counts unoccupied entries. Each valid slot of an accepted group occupies one entry from the next cycle onward. The entry stays occupied, even after dispatch, until the cycle after its tag is written back.
- R4: A source records the tag held in the status table for its register, or ready if that register has no pending producer. A valid earlier slot of the same group that writes that register overrides the table. An accepted register writer makes the table point at its tag, and the latest writer wins.
- R5: A flag reader records the tag in the global flag-producer register, or an earlier flag writer in the same group. It cannot dispatch until that tag is written back. An accepted flag writer becomes the new flag producer.
- R6: An entry is offered only when it is occupied, not yet sent, and none of its two register sources or its flag source is pending.
- R7: At most one instruction leaves per cycle, on `dsp_valid && dsp_ready`. A dispatched entry is never offered again. While not accepted and with no write-back, `dsp_valid` stays high. Tags in flight must be unique.
- R8: When several entries are ready, the one allocated earliest is offered, whatever its entry position. Within one group, a lower slot counts as older.
- R9: Every valid write-back lane (up to `WB_W` per cycle) wakes all entries waiting on its tag, so they can be offered in the next cycle.
- R10: Once a tag is written back, a status-table or flag-producer slot that pointed at it is cleared, and later readers of that register or of the flags are ready at once.
- R11: An instruction accepted in the same cycle that its producer's tag is written back records that source as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue group present |
| iss_ready | output | 1 | Station can take a full group |
| iss_slot_vld | input | ISSUE_W | Per-slot instruction valid |
| iss_tag | input | ISSUE_W x 4 | Per-slot producer tag |
| iss_src_a_use | input | ISSUE_W | Slot reads source A |
| iss_src_a | input | ISSUE_W x log2(NUM_REGS) | Source A register |
| iss_src_b_use | input | ISSUE_W | Slot reads source B |
| iss_src_b | input | ISSUE_W x log2(NUM_REGS) | Source B register |
| iss_dst_we | input | ISSUE_W | Slot writes a register |
| iss_dst | input | ISSUE_W x log2(NUM_REGS) | Destination register |
| iss_flag_rd | input | ISSUE_W | Slot reads flags |
| iss_flag_wr | input | ISSUE_W | Slot writes flags |
| dsp_valid | output | 1 | A ready instruction is offered |
| dsp_ready | input | 1 | Unit takes the offered instruction |
| dsp_tag | output | 4 | Tag of the offered instruction |
| wb_valid | input | WB_W | Per-lane write-back valid |
| wb_tag | input | WB_W x 4 | Per-lane written-back tag |
| free_cnt | output | log2(NUM_ENTRIES+1) | Unoccupied entries |

## Verification
The bench goes after the following corner cases, and what a wrong design would do in each:
- **Age versus position:** an entry is reused at a lower position than an older waiting entry. A station that picks by position would offer the younger tag.
- **Renaming inside a group:** a consumer sits in the same group as its producer, and two writers of one register share a group. Wrong renaming would let the consumer dispatch early, or make it wait on the stale writer.
- **Same-cycle write-back:** a consumer is accepted in the very cycle its producer writes back. A station that misses this case would leave the entry waiting forever.
- **Flags, two-lane wake-up and refused groups:** flag dependencies through both the global register and within a group, two tags written back together, and groups refused while the station is nearly full. Errors there show up as a wrong `free_cnt`, as phantom dispatches, or as a consumer that never wakes.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Chip-wide producer tag width
  localparam int unsigned TAG_W = 4;

  typedef logic [TAG_W-1:0] tag_t;

  // One dependency: pending flag plus the awaited producer tag
  typedef struct packed {
    logic pend;
    tag_t tag;
  } dep_t;

  // One station entry
  typedef struct packed {
    logic occ;
    logic sent;
    tag_t tag;
    dep_t src_a;
    dep_t src_b;
    dep_t flg;
  } slot_t;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ISSUE_W     = 2,
  localparam int unsigned IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned FREE_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic [NUM_ENTRIES-1:0]           occ,
  input  logic [ISSUE_W-1:0]               slot_vld,
  output logic [ISSUE_W-1:0]               slot_hit,
  output logic [ISSUE_W-1:0][IDX_W-1:0]    slot_ent,
  output logic [FREE_W-1:0]                free_cnt
);
  logic [NUM_ENTRIES-1:0] taken;

  // Lowest free entry per valid slot, slots served in program order
  always_comb begin
    taken = occ;
    for (int s = 0; s < ISSUE_W; s++) begin
      slot_ent[s] = '0;
      slot_hit[s] = 1'b0;
      if (slot_vld[s]) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (!taken[e] && !slot_hit[s]) begin
            slot_ent[s] = IDX_W'(e);
            slot_hit[s] = 1'b1;
            taken[e]    = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (!occ[e]) free_cnt = free_cnt + FREE_W'(1);
  end
endmodule

// File: rtl/rs_rename.sv
module rs_rename
  import rs_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ISSUE_W  = 2,
  parameter int unsigned WB_W     = 2,
  localparam int unsigned REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept,
  input  logic [ISSUE_W-1:0]             slot_vld,
  input  logic [ISSUE_W-1:0][TAG_W-1:0]  tag,
  input  logic [ISSUE_W-1:0]             src_a_use,
  input  logic [ISSUE_W-1:0][REG_W-1:0]  src_a,
  input  logic [ISSUE_W-1:0]             src_b_use,
  input  logic [ISSUE_W-1:0][REG_W-1:0]  src_b,
  input  logic [ISSUE_W-1:0]             dst_we,
  input  logic [ISSUE_W-1:0][REG_W-1:0]  dst,
  input  logic [ISSUE_W-1:0]             flag_rd,
  input  logic [ISSUE_W-1:0]             flag_wr,
  input  logic [WB_W-1:0]                wb_valid,
  input  logic [WB_W-1:0][TAG_W-1:0]     wb_tag,
  output dep_t                           dep_a [ISSUE_W],
  output dep_t                           dep_b [ISSUE_W],
  output dep_t                           dep_f [ISSUE_W]
);
  dep_t reg_tab  [NUM_REGS];
  dep_t tab_live [NUM_REGS];
  dep_t tab_nxt  [NUM_REGS];
  dep_t cc_q, cc_live, cc_nxt;

  // Status after this cycle's write-backs (same-cycle bypass)
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      tab_live[r] = reg_tab[r];
      for (int w = 0; w < WB_W; w++)
        if (wb_valid[w] && reg_tab[r].pend && wb_tag[w] == reg_tab[r].tag)
          tab_live[r].pend = 1'b0;
    end
    cc_live = cc_q;
    for (int w = 0; w < WB_W; w++)
      if (wb_valid[w] && cc_q.pend && wb_tag[w] == cc_q.tag)
        cc_live.pend = 1'b0;
  end

  // Per-slot lookup, earlier slots of the group override the table
  always_comb begin
    for (int s = 0; s < ISSUE_W; s++) begin
      dep_a[s] = src_a_use[s] ? tab_live[src_a[s]] : '0;
      dep_b[s] = src_b_use[s] ? tab_live[src_b[s]] : '0;
      dep_f[s] = flag_rd[s]   ? cc_live            : '0;
      for (int p = 0; p < s; p++) begin
        if (slot_vld[p] && dst_we[p] && src_a_use[s] && dst[p] == src_a[s])
          dep_a[s] = '{pend: 1'b1, tag: tag[p]};
        if (slot_vld[p] && dst_we[p] && src_b_use[s] && dst[p] == src_b[s])
          dep_b[s] = '{pend: 1'b1, tag: tag[p]};
        if (slot_vld[p] && flag_wr[p] && flag_rd[s])
          dep_f[s] = '{pend: 1'b1, tag: tag[p]};
      end
    end
  end

  // Table update: clear on write-back, then latest writer in the group wins
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) tab_nxt[r] = tab_live[r];
    cc_nxt = cc_live;
    if (accept) begin
      for (int s = 0; s < ISSUE_W; s++) begin
        if (slot_vld[s] && dst_we[s]) tab_nxt[dst[s]] = '{pend: 1'b1, tag: tag[s]};
        if (slot_vld[s] && flag_wr[s]) cc_nxt = '{pend: 1'b1, tag: tag[s]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) reg_tab[r] <= '0;
      cc_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) reg_tab[r] <= tab_nxt[r];
      cc_q <= cc_nxt;
    end
  end
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ISSUE_W     = 2,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ENTRIES-1:0]        occ,
  input  logic [ISSUE_W-1:0]            alloc_en,
  input  logic [ISSUE_W-1:0][IDX_W-1:0] alloc_ent,
  input  logic [NUM_ENTRIES-1:0]        cand,
  output logic [NUM_ENTRIES-1:0]        pick,
  output logic [IDX_W-1:0]              pick_idx
);
  // older_q[i][j] set: entry i was allocated before entry j
  logic [NUM_ENTRIES-1:0] older_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] older_d [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] prior;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) older_d[i] = older_q[i];
    for (int s = 0; s < ISSUE_W; s++)
      if (alloc_en[s]) older_d[alloc_ent[s]] = '0;
    prior = occ;
    for (int s = 0; s < ISSUE_W; s++) begin
      if (alloc_en[s]) begin
        for (int j = 0; j < NUM_ENTRIES; j++)
          older_d[j][alloc_ent[s]] = prior[j];
        prior[alloc_ent[s]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < NUM_ENTRIES; i++) older_q[i] <= '0;
    else        for (int i = 0; i < NUM_ENTRIES; i++) older_q[i] <= older_d[i];
  end

  // Oldest candidate: no other candidate is older than it
  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      pick[i] = cand[i];
      for (int j = 0; j < NUM_ENTRIES; j++)
        if (j != i && cand[j] && older_q[j][i]) pick[i] = 1'b0;
      if (pick[i]) pick_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned WB_W        = 2,
  parameter int unsigned NUM_REGS    = 8,
  localparam int unsigned IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned FREE_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            iss_valid,
  output logic                            iss_ready,
  input  logic [ISSUE_W-1:0]              iss_slot_vld,
  input  logic [ISSUE_W-1:0][TAG_W-1:0]   iss_tag,
  input  logic [ISSUE_W-1:0]              iss_src_a_use,
  input  logic [ISSUE_W-1:0][REG_W-1:0]   iss_src_a,
  input  logic [ISSUE_W-1:0]              iss_src_b_use,
  input  logic [ISSUE_W-1:0][REG_W-1:0]   iss_src_b,
  input  logic [ISSUE_W-1:0]              iss_dst_we,
  input  logic [ISSUE_W-1:0][REG_W-1:0]   iss_dst,
  input  logic [ISSUE_W-1:0]              iss_flag_rd,
  input  logic [ISSUE_W-1:0]              iss_flag_wr,
  output logic                            dsp_valid,
  input  logic                            dsp_ready,
  output logic [TAG_W-1:0]                dsp_tag,
  input  logic [WB_W-1:0]                 wb_valid,
  input  logic [WB_W-1:0][TAG_W-1:0]      wb_tag,
  output logic [FREE_W-1:0]               free_cnt
);
  slot_t ent_q [NUM_ENTRIES];
  slot_t ent_d [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0]        occ, cand, pick;
  logic [IDX_W-1:0]              pick_idx;
  logic [ISSUE_W-1:0]            slot_hit;
  logic [ISSUE_W-1:0][IDX_W-1:0] slot_ent;
  logic [ISSUE_W-1:0]            alloc_en;
  logic                          accept, fire;
  dep_t                          dep_a [ISSUE_W];
  dep_t                          dep_b [ISSUE_W];
  dep_t                          dep_f [ISSUE_W];

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      occ[e]  = ent_q[e].occ;
      cand[e] = ent_q[e].occ && !ent_q[e].sent &&
                !ent_q[e].src_a.pend && !ent_q[e].src_b.pend && !ent_q[e].flg.pend;
    end
  end

  rs_alloc #(.NUM_ENTRIES(NUM_ENTRIES), .ISSUE_W(ISSUE_W)) u_alloc (
    .occ      (occ),
    .slot_vld (iss_slot_vld),
    .slot_hit (slot_hit),
    .slot_ent (slot_ent),
    .free_cnt (free_cnt)
  );

  assign iss_ready = (int'(free_cnt) >= int'(ISSUE_W));
  assign accept    = iss_valid && iss_ready;
  assign alloc_en  = accept ? slot_hit : '0;

  rs_rename #(.NUM_REGS(NUM_REGS), .ISSUE_W(ISSUE_W), .WB_W(WB_W)) u_rename (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .slot_vld  (iss_slot_vld),
    .tag       (iss_tag),
    .src_a_use (iss_src_a_use),
    .src_a     (iss_src_a),
    .src_b_use (iss_src_b_use),
    .src_b     (iss_src_b),
    .dst_we    (iss_dst_we),
    .dst       (iss_dst),
    .flag_rd   (iss_flag_rd),
    .flag_wr   (iss_flag_wr),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .dep_a     (dep_a),
    .dep_b     (dep_b),
    .dep_f     (dep_f)
  );

  rs_age #(.NUM_ENTRIES(NUM_ENTRIES), .ISSUE_W(ISSUE_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ       (occ),
    .alloc_en  (alloc_en),
    .alloc_ent (slot_ent),
    .cand      (cand),
    .pick      (pick),
    .pick_idx  (pick_idx)
  );

  assign dsp_valid = |cand;
  assign dsp_tag   = ent_q[pick_idx].tag;
  assign fire      = dsp_valid && dsp_ready;

  // Entry update: wake-up, free, mark sent, allocate
  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      logic done;
      ent_d[e] = ent_q[e];
      done     = 1'b0;
      for (int w = 0; w < WB_W; w++) begin
        if (wb_valid[w]) begin
          if (ent_q[e].src_a.pend && ent_q[e].src_a.tag == wb_tag[w]) ent_d[e].src_a.pend = 1'b0;
          if (ent_q[e].src_b.pend && ent_q[e].src_b.tag == wb_tag[w]) ent_d[e].src_b.pend = 1'b0;
          if (ent_q[e].flg.pend   && ent_q[e].flg.tag   == wb_tag[w]) ent_d[e].flg.pend   = 1'b0;
          if (ent_q[e].occ && ent_q[e].tag == wb_tag[w]) done = 1'b1;
        end
      end
      if (fire && pick[e]) ent_d[e].sent = 1'b1;
      if (done) ent_d[e] = '0;
      for (int s = 0; s < ISSUE_W; s++) begin
        if (alloc_en[s] && slot_ent[s] == IDX_W'(e))
          ent_d[e] = '{occ: 1'b1, sent: 1'b0, tag: iss_tag[s],
                       src_a: dep_a[s], src_b: dep_b[s], flg: dep_f[s]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int e = 0; e < NUM_ENTRIES; e++) ent_q[e] <= '0;
    else        for (int e = 0; e < NUM_ENTRIES; e++) ent_q[e] <= ent_d[e];
  end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned WB_W        = 2,
  parameter int unsigned TAG_W       = 4,
  localparam int unsigned FREE_W = $clog2(NUM_ENTRIES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic [ISSUE_W-1:0]  iss_slot_vld,
  input logic                dsp_valid,
  input logic                dsp_ready,
  input logic [TAG_W-1:0]    dsp_tag,
  input logic [WB_W-1:0]     wb_valid,
  input logic [FREE_W-1:0]   free_cnt
);
  // R2
  refused_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && wb_valid == '0) |=> (free_cnt == $past(free_cnt)));

  // R3
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && wb_valid == '0) |=>
      (int'(free_cnt) + $countones($past(iss_slot_vld)) == int'($past(free_cnt))));

  // R3
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && wb_valid == '0) |=> $stable(free_cnt));

  // R7
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && dsp_ready) |=> !(dsp_valid && dsp_tag == $past(dsp_tag)));

  // R7
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready && wb_valid == '0) |=> dsp_valid);

  // R6
  offer_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (int'(free_cnt) < int'(NUM_ENTRIES)));
endmodule

bind rs_station rs_station_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ISSUE_W     (ISSUE_W),
  .WB_W        (WB_W),
  .TAG_W       (rs_pkg::TAG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_valid    (iss_valid),
  .iss_ready    (iss_ready),
  .iss_slot_vld (iss_slot_vld),
  .dsp_valid    (dsp_valid),
  .dsp_ready    (dsp_ready),
  .dsp_tag      (dsp_tag),
  .wb_valid     (wb_valid),
  .free_cnt     (free_cnt)
);

// File: tb/rs_station_bench.sv
module rs_station_bench;
  localparam int NE = 4;
  localparam int IW = 2;
  localparam int WW = 2;
  localparam int NR = 8;
  localparam int TW = 4;
  localparam int RW = 3;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                  iss_valid, iss_ready;
  logic [IW-1:0]         iss_slot_vld;
  logic [IW-1:0][TW-1:0] iss_tag;
  logic [IW-1:0]         iss_src_a_use, iss_src_b_use, iss_dst_we, iss_flag_rd, iss_flag_wr;
  logic [IW-1:0][RW-1:0] iss_src_a, iss_src_b, iss_dst;
  logic                  dsp_valid, dsp_ready;
  logic [TW-1:0]         dsp_tag;
  logic [WW-1:0]         wb_valid;
  logic [WW-1:0][TW-1:0] wb_tag;
  logic [FW-1:0]         free_cnt;

  int n_chk  = 0;
  int n_fail = 0;

  rs_station #(.NUM_ENTRIES(NE), .ISSUE_W(IW), .WB_W(WW), .NUM_REGS(NR)) u_rs_station (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_slot_vld(iss_slot_vld),
    .iss_tag(iss_tag), .iss_src_a_use(iss_src_a_use), .iss_src_a(iss_src_a),
    .iss_src_b_use(iss_src_b_use), .iss_src_b(iss_src_b), .iss_dst_we(iss_dst_we),
    .iss_dst(iss_dst), .iss_flag_rd(iss_flag_rd), .iss_flag_wr(iss_flag_wr),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_tag(dsp_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .free_cnt(free_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    iss_valid = 1'b0; iss_slot_vld = '0; iss_tag = '0;
    iss_src_a_use = '0; iss_src_a = '0; iss_src_b_use = '0; iss_src_b = '0;
    iss_dst_we = '0; iss_dst = '0; iss_flag_rd = '0; iss_flag_wr = '0;
    dsp_ready = 1'b0; wb_valid = '0; wb_tag = '0;
  endtask

  // slot, tag, src A (use, reg), src B (use, reg), dst (we, reg), flags (rd, wr)
  task automatic put(input int s, input int t, input int au, input int a, input int bu,
                     input int b, input int we, input int d, input int fr, input int fw);
    iss_valid = 1'b1;
    iss_slot_vld[s] = 1'b1;       iss_tag[s] = TW'(t);
    iss_src_a_use[s] = au[0];     iss_src_a[s] = RW'(a);
    iss_src_b_use[s] = bu[0];     iss_src_b[s] = RW'(b);
    iss_dst_we[s] = we[0];        iss_dst[s] = RW'(d);
    iss_flag_rd[s] = fr[0];       iss_flag_wr[s] = fw[0];
  endtask

  task automatic wb(input int lane, input int t);
    wb_valid[lane] = 1'b1;
    wb_tag[lane]   = TW'(t);
  endtask

  // Apply current inputs for one edge, then look at the new state
  task automatic step();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic expect_offer(input string req, input int t);
    chk({req, " offer valid"}, int'(dsp_valid), 1);
    chk({req, " offer tag"}, int'(dsp_tag), t);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 free", int'(free_cnt), NE);
    chk("R1 dsp_valid", int'(dsp_valid), 0);
    chk("R1 iss_ready", int'(iss_ready), 1);

    // Fill sweep: n independent instructions, drain oldest first, refuse, release
    for (int n = 1; n <= NE; n++) begin
      for (int g = 0; g < n; g += IW) begin
        for (int s = 0; s < IW && g + s < n; s++) put(s, 1 + g + s, 0, 0, 0, 0, 0, 0, 0, 0);
        step();
      end
      chk("R3 free after fill", int'(free_cnt), NE - n);
      chk("R2 iss_ready", int'(iss_ready), (NE - n >= IW) ? 1 : 0);
      for (int k = 0; k < n; k++) begin
        expect_offer("R8 fill order", 1 + k);
        dsp_ready = 1'b1;
        step();
      end
      chk("R7 nothing left", int'(dsp_valid), 0);
      chk("R3 sent still held", int'(free_cnt), NE - n);
      if (NE - n < IW) begin
        put(0, 9, 0, 0, 0, 0, 0, 0, 0, 0);
        put(1, 10, 0, 0, 0, 0, 0, 0, 0, 0);
        step();
        chk("R2 refused free", int'(free_cnt), NE - n);
        chk("R2 refused offer", int'(dsp_valid), 0);
      end
      for (int w = 0; w < n; w += WW) begin
        for (int l = 0; l < WW && w + l < n; l++) wb(l, 1 + w + l);
        step();
      end
      chk("R9 all released", int'(free_cnt), NE);
    end

    // R8 age beats position: C reuses entry 0 but is younger than B in entry 1
    put(0, 1, 0, 0, 0, 0, 0, 0, 0, 0); put(1, 2, 0, 0, 0, 0, 0, 0, 0, 0); step();
    dsp_ready = 1'b1; step();
    wb(0, 1); step();
    chk("R3 free after one release", int'(free_cnt), 3);
    put(0, 3, 0, 0, 0, 0, 0, 0, 0, 0); step();
    expect_offer("R8 older B", 2);
    dsp_ready = 1'b1; step();
    expect_offer("R8 then C", 3);
    dsp_ready = 1'b1; step();
    wb(0, 2); wb(1, 3); step();

    // R4/R6/R9 in-group producer, consumer waits on source B
    put(0, 5, 0, 0, 0, 0, 1, 3, 0, 0);
    put(1, 6, 1, 0, 1, 3, 0, 0, 0, 0);
    step();
    expect_offer("R6 producer first", 5);
    dsp_ready = 1'b1; step();
    chk("R4 consumer waits in group", int'(dsp_valid), 0);
    wb(0, 5); step();
    expect_offer("R9 woken consumer", 6);
    // R10: register table cleared, new reader of r3 is ready
    put(0, 7, 1, 3, 0, 0, 0, 0, 0, 0);
    dsp_ready = 1'b1; step();
    expect_offer("R10 reader after clear", 7);
    dsp_ready = 1'b1; step();
    wb(0, 6); wb(1, 7); step();

    // R11 same-cycle write-back and issue
    put(0, 8, 0, 0, 0, 0, 1, 4, 0, 0); step();
    dsp_ready = 1'b1; step();
    wb(0, 8); put(0, 9, 1, 4, 0, 0, 0, 0, 0, 0); step();
    expect_offer("R11 bypass", 9);
    dsp_ready = 1'b1; step();
    wb(0, 9); step();

    // R5 flags through the global producer register
    put(0, 10, 0, 0, 0, 0, 0, 0, 0, 1); step();
    put(0, 11, 0, 0, 0, 0, 0, 0, 1, 0); step();
    expect_offer("R5 flag writer", 10);
    dsp_ready = 1'b1; step();
    chk("R5 flag reader waits", int'(dsp_valid), 0);
    wb(0, 10); step();
    expect_offer("R5 flag reader woken", 11);
    put(0, 12, 0, 0, 0, 0, 0, 0, 1, 0);
    dsp_ready = 1'b1; step();
    expect_offer("R10 flag cleared", 12);
    dsp_ready = 1'b1; step();
    wb(0, 11); wb(1, 12); step();

    // R5 flags inside one group
    put(0, 13, 0, 0, 0, 0, 0, 0, 0, 1); put(1, 14, 0, 0, 0, 0, 0, 0, 1, 0); step();
    expect_offer("R5 group writer", 13);
    dsp_ready = 1'b1; step();
    chk("R5 group reader waits", int'(dsp_valid), 0);
    wb(0, 13); step();
    expect_offer("R5 group reader woken", 14);
    dsp_ready = 1'b1; step();
    wb(0, 14); step();

    // R9 two tags on two lanes wake a two-source consumer
    put(0, 1, 0, 0, 0, 0, 1, 1, 0, 0); put(1, 2, 0, 0, 0, 0, 1, 2, 0, 0); step();
    put(0, 3, 1, 1, 1, 2, 0, 0, 0, 0); step();
    chk("R3 three held", int'(free_cnt), 1);
    expect_offer("R8 first of pair", 1);
    dsp_ready = 1'b1; step();
    expect_offer("R8 second of pair", 2);
    dsp_ready = 1'b1; step();
    chk("R6 both sources pending", int'(dsp_valid), 0);
    wb(0, 1); wb(1, 2); step();
    chk("R9 two freed", int'(free_cnt), 3);
    expect_offer("R9 dual wake", 3);
    dsp_ready = 1'b1; step();
    wb(0, 3); step();

    // R4 latest writer of a register in a group wins
    put(0, 4, 0, 0, 0, 0, 1, 5, 0, 0); put(1, 5, 0, 0, 0, 0, 1, 5, 0, 0); step();
    put(0, 6, 1, 5, 0, 0, 0, 0, 0, 0); step();
    dsp_ready = 1'b1; step();
    dsp_ready = 1'b1; step();
    wb(0, 4); step();
    chk("R4 waits on latest writer", int'(dsp_valid), 0);
    wb(0, 5); step();
    expect_offer("R4 latest writer done", 6);
    dsp_ready = 1'b1; step();
    wb(0, 6); step();
    chk("R3 empty at end", int'(free_cnt), NE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule